// File: doc/BRIEF.md
# Sequential Multi-Stage Capture Trigger

This block decides when a sampling logic analyzer starts recording. It watches a 32-channel sample word that arrives with a valid strobe, and it works through a chain of up to four trigger conditions. The conditions must be met one after another over time. When the last enabled condition is met, the block raises a capture-start level and emits a trigger-output pulse of programmable length.

Each condition compares a masked value in one of two ways. It can compare against all channels of the current sample at once. It can also compare against a 32-bit history of one selected channel, which catches serial bit patterns. Software writes the conditions and the pulse length through a small register-write port. An arm input restarts the sequence, and it keeps the written configuration.

Top module: `seq_trigger`

## Requirements
- R1: After reset, capture_start and trig_out are low, every stage is disabled and the pulse length is 0.
- R2: A parallel-mode stage matches a valid sample when every channel whose mask bit is 1 equals its value bit. Channels whose mask bit is 0 do not affect the result.
- R3: A serial-mode stage compares its mask and value against a 32-bit history of its selected channel. The sample being judged is at bit 0 and older samples are at higher bits. The history shifts only on valid samples, and all stages keep their histories whatever their mode.
- R4: Stages are satisfied strictly in index order. A match at one stage is registered, and the next enabled stage is first judged on the following valid sample, so one sample never satisfies two stages.
- R5: Stages with their enable bit clear are skipped. If no stage is enabled, the first valid sample after arming starts the capture.
- R6: capture_start goes high on the clock edge that takes the valid sample satisfying the last enabled stage. It stays high until arm, and later samples have no effect.
- R7: arm returns the sequence to stage 0, clears all serial histories and drops capture_start and trig_out. An arm takes priority over a sample in the same cycle, and it keeps the configuration.
- R8: trig_out is high for exactly the programmed pulse length in clock cycles, starting in the same cycle as capture_start. A length of 0 gives no pulse.
- R9: A write with cfg_we high is decoded by cfg_field. 0 writes the stage mask and 1 writes the stage value. 2 writes the stage control word: bit 0 is enable, bit 1 selects serial mode, and bits 6:2 give the channel. 3 writes the pulse length from the low bits of cfg_wdata, whatever cfg_stage holds. A write takes effect from the next cycle.
- R10: Samples with smp_valid low are ignored. They do not advance the stage, shift the histories or start a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Restart the trigger sequence |
| smp_valid | input | 1 | Sample word is valid this cycle |
| smp_data | input | 32 | Sample word, one bit per channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_stage | input | 2 | Stage addressed by the write |
| cfg_field | input | 2 | Field addressed by the write |
| cfg_wdata | input | 32 | Write data |
| capture_start | output | 1 | Level that starts the capture |
| trig_out | output | 1 | Trigger-output pulse |

## Verification
If the stage index goes wrong, the error shows at capture_start on the next valid sample. Capture then starts one sample too early when a stage is skipped, or it never starts when a stage repeats. If a serial history goes wrong, for example by shifting on invalid cycles or in the wrong direction, capture comes on the wrong sample of a bit pattern. The pulse counter is checked against the length on every cycle of trig_out. A reference model in the bench follows every cycle, so the run reports any difference in the first cycle where it appears.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int CH_W  = 32;
    localparam int SEL_W = $clog2(CH_W);

    typedef enum logic [1:0] {
        FLD_MASK  = 2'd0,
        FLD_VALUE = 2'd1,
        FLD_CTRL  = 2'd2,
        FLD_PLEN  = 2'd3
    } cfg_field_e;

    typedef struct packed {
        logic [CH_W-1:0]  mask;
        logic [CH_W-1:0]  value;
        logic             en;
        logic             serial;
        logic [SEL_W-1:0] sel;
    } stage_cfg_t;

    // true when all cared-for bits agree
    function automatic logic masked_eq(input logic [CH_W-1:0] word,
                                       input logic [CH_W-1:0] value,
                                       input logic [CH_W-1:0] mask);
        return ((word ^ value) & mask) == '0;
    endfunction
endpackage

// File: rtl/trig_stage_eval.sv
module trig_stage_eval
    import trig_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            smp_valid,
    input  logic [CH_W-1:0] smp_data,
    input  stage_cfg_t      cfg,
    output logic            hit
);
    logic [CH_W-1:0] hist_q;
    logic [CH_W-1:0] hist_next;
    logic [CH_W-1:0] operand;

    assign hist_next = {hist_q[CH_W-2:0], smp_data[cfg.sel]};
    assign operand   = cfg.serial ? hist_next : smp_data;
    assign hit       = masked_eq(operand, cfg.value, cfg.mask);

    always_ff @(posedge clk) begin
        if (rst || clr)
            hist_q <= '0;
        else if (smp_valid)
            hist_q <= hist_next;
    end
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen #(
    parameter int PULSE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               start,
    input  logic [PULSE_W-1:0] len,
    output logic               pulse
);
    logic [PULSE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (start)
            cnt_q <= len;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign pulse = (cnt_q != '0);
endmodule

// File: rtl/seq_trigger.sv
module seq_trigger
    import trig_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int PULSE_W    = 16,
    localparam int STG_W     = $clog2(NUM_STAGES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             smp_valid,
    input  logic [CH_W-1:0]  smp_data,
    input  logic             cfg_we,
    input  logic [STG_W-1:0] cfg_stage,
    input  logic [1:0]       cfg_field,
    input  logic [CH_W-1:0]  cfg_wdata,
    output logic             capture_start,
    output logic             trig_out
);
    stage_cfg_t         cfg_q [NUM_STAGES];
    logic [PULSE_W-1:0] plen_q;
    logic [NUM_STAGES-1:0] hit;
    logic [NUM_STAGES-1:0] stg_en;
    logic [STG_W-1:0]   idx_q;
    logic               cap_q;
    logic [STG_W-1:0]   cur;
    logic               found;
    logic               more;
    logic               fire;
    logic               advance;

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_STAGES; i++) cfg_q[i] <= '0;
            plen_q <= '0;
        end else if (cfg_we) begin
            case (cfg_field_e'(cfg_field))
                FLD_MASK:  cfg_q[cfg_stage].mask  <= cfg_wdata;
                FLD_VALUE: cfg_q[cfg_stage].value <= cfg_wdata;
                FLD_CTRL: begin
                    cfg_q[cfg_stage].en     <= cfg_wdata[0];
                    cfg_q[cfg_stage].serial <= cfg_wdata[1];
                    cfg_q[cfg_stage].sel    <= cfg_wdata[2 +: SEL_W];
                end
                default:   plen_q <= cfg_wdata[PULSE_W-1:0];
            endcase
        end
    end

    // one evaluator per stage
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        assign stg_en[g] = cfg_q[g].en;
        trig_stage_eval u_eval (
            .clk       (clk),
            .rst       (rst),
            .clr       (arm),
            .smp_valid (smp_valid),
            .smp_data  (smp_data),
            .cfg       (cfg_q[g]),
            .hit       (hit[g])
        );
    end

    // pick the active stage: first enabled one at or above the index
    always_comb begin
        found = 1'b0;
        cur   = '0;
        for (int i = 0; i < NUM_STAGES; i++) begin
            if (!found && i >= int'(idx_q) && stg_en[i]) begin
                found = 1'b1;
                cur   = STG_W'(i);
            end
        end
        more = 1'b0;
        for (int j = 0; j < NUM_STAGES; j++) begin
            if (found && j > int'(cur) && stg_en[j]) more = 1'b1;
        end
        fire    = smp_valid && !cap_q && (!found || (hit[cur] && !more));
        advance = smp_valid && !cap_q && found && hit[cur] && more;
    end

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            idx_q <= '0;
            cap_q <= 1'b0;
        end else if (fire) begin
            cap_q <= 1'b1;
        end else if (advance) begin
            idx_q <= cur + 1'b1;
        end
    end

    trig_pulse_gen #(.PULSE_W(PULSE_W)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .clr   (arm),
        .start (fire && !arm),
        .len   (plen_q),
        .pulse (trig_out)
    );

    assign capture_start = cap_q;
endmodule

// File: rtl/seq_trigger_chk.sv
module seq_trigger_chk (
    input logic clk,
    input logic rst,
    input logic arm,
    input logic smp_valid,
    input logic capture_start,
    input logic trig_out
);
    // R6: capture level holds until arm
    assert_capture_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (capture_start && !arm) |=> capture_start);

    // R7: arm drops both outputs
    assert_arm_clears_R7: assert property (@(posedge clk) disable iff (rst)
        arm |=> (!capture_start && !trig_out));

    // R8: pulse begins together with capture
    assert_pulse_align_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_out) |-> $rose(capture_start));

    // R8: no pulse without capture
    assert_pulse_needs_cap_R8: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> capture_start);

    // R10: capture only rises after a valid sample
    assert_no_cap_invalid_R10: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !capture_start) |=> !capture_start);
endmodule

bind seq_trigger seq_trigger_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .arm           (arm),
    .smp_valid     (smp_valid),
    .capture_start (capture_start),
    .trig_out      (trig_out)
);

// File: tb/seq_trigger_tb_top.sv
`timescale 1ns/1ps
module seq_trigger_tb_top;
    localparam int NS = 4;
    localparam int PW = 16;

    logic        clk = 1'b0;
    logic        rst, arm, smp_valid, cfg_we;
    logic [31:0] smp_data, cfg_wdata;
    logic [1:0]  cfg_stage, cfg_field;
    logic        capture_start, trig_out;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // reference model state
    logic [31:0] m_mask [NS];
    logic [31:0] m_val  [NS];
    logic        m_en   [NS];
    logic        m_ser  [NS];
    logic [4:0]  m_sel  [NS];
    logic [31:0] m_hist [NS];
    logic [PW-1:0] m_plen, m_cnt;
    int          m_idx;
    logic        m_cap;

    always #2.5 clk = ~clk;

    seq_trigger #(.NUM_STAGES(NS), .PULSE_W(PW)) dut_i (
        .clk(clk), .rst(rst), .arm(arm), .smp_valid(smp_valid),
        .smp_data(smp_data), .cfg_we(cfg_we), .cfg_stage(cfg_stage),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .capture_start(capture_start), .trig_out(trig_out)
    );

    function automatic logic stage_hit(int s, logic [31:0] d);
        logic [31:0] w;
        w = m_ser[s] ? {m_hist[s][30:0], d[m_sel[s]]} : d;
        return ((w ^ m_val[s]) & m_mask[s]) == 32'h0;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_mask[s] = '0; m_val[s] = '0; m_en[s] = 0; m_ser[s] = 0;
            m_sel[s] = '0; m_hist[s] = '0;
        end
        m_plen = '0; m_cnt = '0; m_idx = 0; m_cap = 0;
    endtask

    task automatic model_step(logic a, logic v, logic [31:0] d, logic we,
                              int stg, int fld, logic [31:0] wd);
        int cur; bit found, more, fire;
        if (a) begin
            m_idx = 0; m_cap = 0; m_cnt = '0;
            for (int s = 0; s < NS; s++) m_hist[s] = '0;
        end else begin
            found = 0; cur = 0; more = 0; fire = 0;
            for (int i = 0; i < NS; i++)
                if (!found && i >= m_idx && m_en[i]) begin found = 1; cur = i; end
            for (int j = 0; j < NS; j++)
                if (found && j > cur && m_en[j]) more = 1;
            if (v && !m_cap) begin
                if (!found || (stage_hit(cur, d) && !more)) fire = 1;
                else if (stage_hit(cur, d)) m_idx = cur + 1;
            end
            if (fire) begin m_cap = 1; m_cnt = m_plen; end
            else if (m_cnt != 0) m_cnt = m_cnt - 1'b1;
            if (v)
                for (int s = 0; s < NS; s++)
                    m_hist[s] = {m_hist[s][30:0], d[m_sel[s]]};
        end
        if (we) begin
            case (fld)
                0: m_mask[stg] = wd;
                1: m_val[stg]  = wd;
                2: begin m_en[stg] = wd[0]; m_ser[stg] = wd[1]; m_sel[stg] = wd[6:2]; end
                default: m_plen = wd[PW-1:0];
            endcase
        end
    endtask

    task automatic check_outputs();
        checks++;
        if (capture_start !== m_cap || trig_out !== (m_cnt != 0)) begin
            fails++;
            $display("FAIL %s: capture_start=%0b trig_out=%0b expected %0b %0b",
                     tag, capture_start, trig_out, m_cap, (m_cnt != 0));
        end
    endtask

    // one clock: drive at negedge, model the edge, compare at the next negedge
    task automatic cyc(logic a, logic v, logic [31:0] d, logic we = 0,
                       int stg = 0, int fld = 0, logic [31:0] wd = 0);
        arm = a; smp_valid = v; smp_data = d; cfg_we = we;
        cfg_stage = 2'(stg); cfg_field = 2'(fld); cfg_wdata = wd;
        model_step(a, v, d, we, stg, fld, wd);
        @(posedge clk);
        @(negedge clk);
        check_outputs();
    endtask

    task automatic wr(int stg, int fld, logic [31:0] wd);
        cyc(0, 0, $urandom, 1, stg, fld, wd);
    endtask

    task automatic clear_stages();
        for (int s = 0; s < NS; s++) wr(s, 2, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; arm = 0; smp_valid = 0; smp_data = 0; cfg_we = 0;
        cfg_stage = 0; cfg_field = 0; cfg_wdata = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        tag = "R1"; check_outputs();

        // R10 then R5: nothing enabled, idle cycles do nothing
        tag = "R10"; cyc(0, 0, 32'hFFFF_FFFF); cyc(0, 0, 32'h0);
        tag = "R5";  cyc(0, 1, 32'h1234); cyc(0, 1, 32'h0);
        tag = "R8";  repeat (2) cyc(0, 0, 0);

        // R9 / R2 / R8: parallel stage 0, pulse length 3
        tag = "R9";
        wr(0, 3, 32'd3); wr(0, 0, 32'h0000_00FF); wr(0, 1, 32'h0000_005A); wr(0, 2, 32'h1);
        tag = "R7"; cyc(1, 0, 0);
        tag = "R2"; cyc(0, 1, 32'h0000_005B); cyc(0, 1, 32'hABCD_005A);
        tag = "R8"; repeat (5) cyc(0, 0, 0);
        tag = "R6"; cyc(0, 1, 32'h0); cyc(0, 1, 32'h5A);

        // R4: two stages with the same condition
        tag = "R4";
        wr(1, 0, 32'h0000_00FF); wr(1, 1, 32'h0000_005A); wr(1, 2, 32'h1);
        cyc(1, 0, 0); cyc(0, 1, 32'h5A); cyc(0, 0, 32'h5A); cyc(0, 1, 32'h5A);
        repeat (4) cyc(0, 0, 0);

        // R5: only stage 3 enabled
        tag = "R5";
        clear_stages();
        wr(3, 0, 32'h8000_0000); wr(3, 1, 32'h8000_0000); wr(3, 2, 32'h1);
        cyc(1, 0, 0); cyc(0, 1, 32'h7FFF_FFFF); cyc(0, 1, 32'h8000_0000);
        repeat (4) cyc(0, 0, 0);

        // R3: serial pattern 1011 on channel 5, invalid cycles in between
        tag = "R3";
        clear_stages();
        wr(0, 0, 32'hF); wr(0, 1, 32'hB); wr(0, 2, (32'd5 << 2) | 32'h3);
        cyc(1, 0, 0);
        cyc(0, 1, 32'h20); cyc(0, 0, 32'h0);
        cyc(0, 1, 32'h00); cyc(0, 0, 32'hFFFF_FFFF);
        cyc(0, 1, 32'h20); cyc(0, 1, 32'h20);
        repeat (4) cyc(0, 0, 0);

        // R7: arm mid-sequence restarts at stage 0
        tag = "R7";
        clear_stages();
        wr(0, 0, 32'h1); wr(0, 1, 32'h1); wr(0, 2, 32'h1);
        wr(1, 0, 32'h2); wr(1, 1, 32'h2); wr(1, 2, 32'h1);
        cyc(1, 0, 0); cyc(0, 1, 32'h1); cyc(1, 1, 32'h2); cyc(0, 1, 32'h2);
        cyc(0, 1, 32'h1); cyc(0, 1, 32'h2);
        repeat (4) cyc(0, 0, 0);

        // random configurations and traffic
        tag = "R2";
        for (int round = 0; round < 60; round++) begin
            for (int s = 0; s < NS; s++) begin
                wr(s, 0, $urandom & $urandom & $urandom & $urandom);
                wr(s, 1, $urandom);
                wr(s, 2, $urandom & 32'h7F);
            end
            wr(0, 3, $urandom_range(0, 6));
            cyc(1, 0, 0);
            for (int k = 0; k < 150; k++) begin
                logic [31:0] d;
                d = ($urandom_range(0, 1) == 1) ? $urandom : {$urandom_range(0, 15), 28'h0} | 32'(k & 3);
                cyc($urandom_range(0, 60) == 0, $urandom_range(0, 3) != 0, d,
                    $urandom_range(0, 40) == 0, $urandom_range(0, 3),
                    $urandom_range(0, 3), $urandom);
            end
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule